// File: doc/BRIEF.md
# Flash Write Cycle Qualifier

This block watches the asynchronous bus strobes of a parallel NOR-flash-style device (chip enable, write enable and output enable, all active low) together with a low-supply lockout flag. It samples them through a synchronizer and decides when a genuine bus write has taken place. For each genuine write it presents the address and data of that write to a downstream command decoder, with a strobe that lasts one clock.

A write is the interval in which chip enable and write enable are both low. The address is taken when the second of the two strobes falls, which is the start of that interval. The data is taken as it stood in the last sample before the first of the two strobes rises. The interval is rejected in four cases: it lasts fewer samples than a configurable minimum (glitch rejection); output enable is low at any sample inside it; the lockout flag is raised at any sample inside it; or it began before the block was ready, for example with both strobes already held low through reset.

The address and data buses are delayed by the same number of synchronizer stages as the strobes, so each sample of the bus lines up with the strobe sample it belongs to. The synchronizer resets to the inhibiting values: both strobes low, output enable low and lockout set. Because of this, a strobe that is held low through reset is never seen as a fresh falling edge.

Top module: `flash_wr_qual`

## Requirements
- R1: While reset is applied and after it is released, `cmd_stb` is 0 and `cmd_addr` and `cmd_data` are all zeros until the first accepted write.
- R2: An interval in which `chip_en_n` and `wr_en_n` are both sampled low for at least MIN_PULSE_CYCLES consecutive clocks, with `out_en_n` high and `vlow_lock` low in every one of those samples, produces exactly one `cmd_stb` pulse one clock wide. The pulse is high in the clock that follows the SYNC_STAGES+1'th rising edge after the first sample in which either strobe is high again.
- R3: `cmd_addr` carries the `bus_addr` value present in the first sample in which both strobes are low, which is the later of the two falling edges, whichever strobe falls last. Address changes later in the interval are not taken.
- R4: `cmd_data` carries the `bus_data` value present in the last sample in which both strobes are low. Data present once the first strobe has risen is not taken.
- R5: An interval of both strobes low that lasts fewer than MIN_PULSE_CYCLES samples produces no `cmd_stb`.
- R6: If `out_en_n` is sampled low at any sample of the interval, including its first sample, the interval produces no `cmd_stb`, even if `out_en_n` returns high while both strobes are still low.
- R7: If `vlow_lock` is sampled high at any sample of the interval, the interval produces no `cmd_stb`.
- R8: If both strobes are held low through reset, releasing them produces no `cmd_stb`. The next write that starts properly is accepted.
- R9: `cmd_addr` and `cmd_data` change only in the clock where `cmd_stb` is high, and hold their value through rejected intervals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en_n | input | 1 | Chip enable strobe, active low, asynchronous |
| wr_en_n | input | 1 | Write enable strobe, active low, asynchronous |
| out_en_n | input | 1 | Output enable, active low; low inhibits writes |
| vlow_lock | input | 1 | High while supply is below the lockout level |
| bus_addr | input | ADDR_W | Address bus |
| bus_data | input | DATA_W | Data bus |
| cmd_stb | output | 1 | One-clock pulse for each accepted write |
| cmd_addr | output | ADDR_W | Address of the last accepted write |
| cmd_data | output | DATA_W | Data of the last accepted write |

## Verification
The main function is driven with writes in which either strobe falls last, and with address and data buses that carry decoy values before the interval, inside it and after it. This shows that the address comes from the second falling edge and the data from the last sample before the first rising edge. Intervals exactly MIN_PULSE_CYCLES long and one sample shorter mark the glitch boundary. Intervals much longer than the minimum show that the saturating count still accepts them. Single-sample pulses of output enable or lockout, placed at the first sample and in the middle of an interval, show that every inhibit applies across the whole interval. A run with both strobes held low through reset separates the power-up inhibit from ordinary acceptance.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef enum logic [1:0] {
    WQ_WAIT  = 2'd0,
    WQ_IDLE  = 2'd1,
    WQ_LOW   = 2'd2,
    WQ_ABORT = 2'd3
  } wq_state_e;
endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
  parameter int          WIDTH     = 1,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RESET_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wq_pulse_timer.sv
module wq_pulse_timer #(
  parameter int MIN_PULSE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic inc,
  output logic long_enough
);
  localparam int CW = (MIN_PULSE_CYCLES < 2) ? 1 : $clog2(MIN_PULSE_CYCLES + 1);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_PULSE_CYCLES);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)                    cnt_d = ONE_C;
    else if (inc && cnt_q < MIN_C) cnt_d = cnt_q + ONE_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign long_enough = (cnt_q >= MIN_C);

  // R5: the saturating count never passes the threshold
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MIN_C);
endmodule

// File: rtl/flash_wr_qual.sv
module flash_wr_qual
  import wq_pkg::*;
#(
  parameter int ADDR_W           = 20,
  parameter int DATA_W           = 16,
  parameter int SYNC_STAGES      = 2,
  parameter int MIN_PULSE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en_n,
  input  logic              wr_en_n,
  input  logic              out_en_n,
  input  logic              vlow_lock,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              cmd_stb,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int BUS_W = ADDR_W + DATA_W;
  // control order {lock, oe_n, we_n, ce_n}; reset to the inhibiting values
  localparam logic [3:0] CTL_RST = 4'b1000;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // synchronized strobes and aligned bus
  logic [3:0]       ctl_s;
  logic [BUS_W-1:0] bus_s;
  logic             ce_s, we_s, oe_s, lk_s;
  logic [ADDR_W-1:0] a_s;
  logic [DATA_W-1:0] d_s;

  wq_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(CTL_RST)) u_ctl_sync (
    .clk(clk), .rst_n(rst_ni),
    .d({vlow_lock, out_en_n, wr_en_n, chip_en_n}), .q(ctl_s)
  );
  wq_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_ni), .d({bus_addr, bus_data}), .q(bus_s)
  );

  assign {lk_s, oe_s, we_s, ce_s} = ctl_s;
  assign {a_s, d_s} = bus_s;

  logic strb_low, path_ok;
  assign strb_low = ~ce_s & ~we_s;
  assign path_ok  = oe_s & ~lk_s;

  // sequencing
  wq_state_e st_q, st_d;
  logic start, inc, cap_a_en, cap_d_en, fire, long_enough;
  logic [ADDR_W-1:0] cap_a_q;
  logic [DATA_W-1:0] cap_d_q;

  wq_pulse_timer #(.MIN_PULSE_CYCLES(MIN_PULSE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_ni), .start(start), .inc(inc), .long_enough(long_enough)
  );

  always_comb begin
    st_d     = st_q;
    start    = 1'b0;
    inc      = 1'b0;
    cap_a_en = 1'b0;
    cap_d_en = 1'b0;
    fire     = 1'b0;
    case (st_q)
      WQ_WAIT: begin
        if (!strb_low) st_d = WQ_IDLE;
      end
      WQ_IDLE: begin
        if (strb_low) begin
          if (path_ok) begin
            st_d     = WQ_LOW;
            start    = 1'b1;
            cap_a_en = 1'b1;
            cap_d_en = 1'b1;
          end else begin
            st_d = WQ_ABORT;
          end
        end
      end
      WQ_LOW: begin
        if (!strb_low) begin
          fire = long_enough;
          st_d = WQ_IDLE;
        end else if (!path_ok) begin
          st_d = WQ_ABORT;
        end else begin
          inc      = 1'b1;
          cap_d_en = 1'b1;
        end
      end
      default: begin
        if (!strb_low) st_d = WQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= WQ_WAIT;
      cap_a_q  <= '0;
      cap_d_q  <= '0;
      cmd_stb  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      st_q    <= st_d;
      cmd_stb <= fire;
      if (cap_a_en) cap_a_q <= a_s;
      if (cap_d_en) cap_d_q <= d_s;
      if (fire) begin
        cmd_addr <= cap_a_q;
        cmd_data <= cap_d_q;
      end
    end
  end

  // R2: strobe lasts one clock
  assert_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_stb |=> !cmd_stb);
  // R9: outputs hold between strobes
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !cmd_stb |-> ($stable(cmd_addr) && $stable(cmd_data)));
  // R6: the last in-interval sample had output enable high
  assert_oe_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_stb |-> $past(oe_s, 2));
  // R7: the last in-interval sample had lockout clear
  assert_lock_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    cmd_stb |-> !$past(lk_s, 2));
endmodule

// File: tb/flash_wr_qual_test.sv
`timescale 1ns/1ps
module flash_wr_qual_test;
  localparam int AW  = 20;
  localparam int DW  = 16;
  localparam int MIN = 3;
  localparam int SYN = 2;

  logic clk, rst_n, chip_en_n, wr_en_n, out_en_n, vlow_lock;
  logic [AW-1:0] bus_addr, cmd_addr;
  logic [DW-1:0] bus_data, cmd_data;
  logic cmd_stb;

  int checks, failures;
  int pcnt, stb_cnt, stb_at, rel_at, wide;
  logic prev_stb;
  bit done;

  flash_wr_qual #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYN), .MIN_PULSE_CYCLES(MIN)) uut (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .wr_en_n(wr_en_n),
    .out_en_n(out_en_n), .vlow_lock(vlow_lock), .bus_addr(bus_addr), .bus_data(bus_data),
    .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) pcnt++;
  always @(negedge clk) begin
    if (cmd_stb) begin
      stb_cnt++;
      stb_at = pcnt;
      if (prev_stb) wide++;
    end
    prev_stb = cmd_stb;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic ce, input logic we);
    @(negedge clk);
    rst_n = 1'b0; chip_en_n = ce; wr_en_n = we; out_en_n = 1'b1; vlow_lock = 1'b0;
    bus_addr = '0; bus_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // one bus write; inj_oe / inj_lk pulse the inhibit at that low sample (-1: none)
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n_low,
                           input bit ce_first, input int inj_oe, input int inj_lk);
    @(negedge clk);
    if (ce_first) chip_en_n = 1'b0; else wr_en_n = 1'b0;
    bus_addr = ~a; bus_data = ~d;
    for (int i = 0; i < n_low; i++) begin
      @(negedge clk);
      if (i == 0) begin chip_en_n = 1'b0; wr_en_n = 1'b0; end
      bus_addr  = (i == 0) ? a : ~a;
      bus_data  = (i == n_low - 1) ? d : ~d;
      out_en_n  = (i == inj_oe) ? 1'b0 : 1'b1;
      vlow_lock = (i == inj_lk) ? 1'b1 : 1'b0;
    end
    @(negedge clk);
    rel_at = pcnt;
    if (ce_first) wr_en_n = 1'b1; else chip_en_n = 1'b1;
    bus_data = d ^ 16'h5A5A; out_en_n = 1'b1; vlow_lock = 1'b0;
    @(negedge clk);
    chip_en_n = 1'b1; wr_en_n = 1'b1; bus_addr = '0; bus_data = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    apply_reset(1'b1, 1'b1);
    chk("R1 stb", cmd_stb, 0);
    chk("R1 addr", cmd_addr, 0);
    chk("R1 data", cmd_data, 0);
  endtask

  task automatic t_timing;
    int n0, w0;
    n0 = stb_cnt; w0 = wide;
    bus_write(20'h12345, 16'hBEEF, MIN, 1'b0, -1, -1);
    chk("R2 count", stb_cnt - n0, 1);
    chk("R2 latency", stb_at - rel_at, SYN + 1);
    chk("R2 width", wide - w0, 0);
    chk("R3 addr we-first", cmd_addr, 20'h12345);
    chk("R4 data", cmd_data, 16'hBEEF);
  endtask

  task automatic t_patterns;
    int n0;
    n0 = stb_cnt;
    bus_write(20'hA0F0F, 16'h1234, MIN + 5, 1'b1, -1, -1);
    chk("R2 long count", stb_cnt - n0, 1);
    chk("R3 addr ce-first", cmd_addr, 20'hA0F0F);
    chk("R4 data long", cmd_data, 16'h1234);
    bus_write(20'h00001, 16'hFFFF, MIN + 1, 1'b0, -1, -1);
    chk("R2 second count", stb_cnt - n0, 2);
    chk("R3 addr second", cmd_addr, 20'h00001);
    chk("R4 data second", cmd_data, 16'hFFFF);
  endtask

  task automatic t_glitch;
    int n0;
    n0 = stb_cnt;
    bus_write(20'h77777, 16'h7777, MIN - 1, 1'b0, -1, -1);
    chk("R5 short count", stb_cnt - n0, 0);
    chk("R9 addr hold", cmd_addr, 20'h00001);
    chk("R9 data hold", cmd_data, 16'hFFFF);
    bus_write(20'h66666, 16'h6666, 1, 1'b1, -1, -1);
    chk("R5 single count", stb_cnt - n0, 0);
  endtask

  task automatic t_oe;
    int n0;
    n0 = stb_cnt;
    bus_write(20'h11111, 16'h1111, MIN + 2, 1'b0, 0, -1);
    chk("R6 oe at start", stb_cnt - n0, 0);
    bus_write(20'h22222, 16'h2222, MIN + 2, 1'b1, 2, -1);
    chk("R6 oe mid", stb_cnt - n0, 0);
    chk("R9 addr after oe", cmd_addr, 20'h00001);
  endtask

  task automatic t_lock;
    int n0;
    n0 = stb_cnt;
    bus_write(20'h33333, 16'h3333, MIN + 2, 1'b0, -1, 0);
    chk("R7 lock at start", stb_cnt - n0, 0);
    bus_write(20'h44444, 16'h4444, MIN + 2, 1'b0, -1, 3);
    chk("R7 lock mid", stb_cnt - n0, 0);
    bus_write(20'h55555, 16'h5555, MIN, 1'b0, -1, -1);
    chk("R7 clear accepted", stb_cnt - n0, 1);
    chk("R7 clear addr", cmd_addr, 20'h55555);
  endtask

  task automatic t_powerup;
    int n0;
    apply_reset(1'b0, 1'b0);
    n0 = stb_cnt;
    chk("R1 addr after reset", cmd_addr, 0);
    repeat (4) @(negedge clk);
    wr_en_n = 1'b1;
    repeat (3) @(negedge clk);
    chip_en_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 held low rejected", stb_cnt - n0, 0);
    bus_write(20'h9ABCD, 16'hC0DE, MIN, 1'b1, -1, -1);
    chk("R8 next accepted", stb_cnt - n0, 1);
    chk("R8 next data", cmd_data, 16'hC0DE);
  endtask

  initial begin
    checks = 0; failures = 0; pcnt = 0; stb_cnt = 0; stb_at = 0; rel_at = 0; wide = 0;
    prev_stb = 1'b0; done = 1'b0;
    rst_n = 1'b0; chip_en_n = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b1; vlow_lock = 1'b0;
    bus_addr = '0; bus_data = '0;
    t_reset;
    t_timing;
    t_patterns;
    t_glitch;
    t_oe;
    t_lock;
    t_powerup;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule